// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an asynchronous static RAM of 1024 four-bit words with one shared data bus. The host raises a one-cycle request with a read/write flag, an address and write data. The sequencer then moves the memory's active-low select, active-low write strobe, address lines and data drive through a fixed series of phases. The length of each phase is a whole number of clock cycles. It is worked out at elaboration from a nanosecond minimum, divided by the clock period and rounded up, with a floor of one cycle. When the access ends, read data appears on `rd_data` and `done` pulses for one clock.

There are eight states. `ST_IDLE` waits for work. `ST_READ` holds select low with the write strobe high for the access time. A write passes through four states. `ST_WSETUP` holds the address under select before the strobe falls. `ST_WPULSE` holds the strobe low and drives data. `ST_WHOLD` raises the strobe but keeps the address, select and data. `ST_WGAP` deselects the memory and releases the bus. A retention request moves the block from idle to `ST_RETAIN`, where the memory stays deselected. Dropping the request enters `ST_RECOVER`, which waits one read-cycle time.

The transitions are:
- IDLE→RETAIN when retention is requested. This takes priority over a request in the same cycle.
- IDLE→READ or IDLE→WSETUP when a request is accepted.
- READ→IDLE, WSETUP→WPULSE, WPULSE→WHOLD, WHOLD→WGAP and WGAP→IDLE when the phase timer expires.
- RETAIN→RECOVER when retention drops.
- RECOVER→IDLE when the timer expires, or RECOVER→RETAIN if retention returns.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted, and right after it, select and write strobe are high (inactive), data drive is off and `done` is low.
- R2: A read holds select low and the write strobe high for exactly the read phase (50 cycles by default: max of 200 ns access and 200 ns cycle at 4 ns). `rd_data` then returns the word the memory drove at the final cycle.
- R3: In a write, select is low with a stable address for the setup phase before the strobe falls (7 cycles for 25 ns). The strobe then stays low for max(write pulse, data setup) (32 cycles for 125 ns / 75 ns).
- R4: After the strobe rises, select stays low and the address and write data are held for max(write release, data hold) (13 cycles for 50 ns / 30 ns).
- R5: Data drive is on only while select is low and the strobe is low or in the hold phase. It is never on during a read. Select is high for at least one cycle between a write and the next access.
- R6: `done` is high for exactly one cycle per accepted access. For a read it rises in the cycle after select rises. For a write it rises one cycle after the one-cycle gap.
- R7: Requests that arrive while an access is in progress are ignored. They produce no `done` and no change to memory.
- R8: While retention is requested and no access is running, select stays high and requests are ignored. A retention request in the same cycle as an access request wins.
- R9: After retention drops, the block waits the recovery phase (50 cycles for 200 ns), plus one cycle to return to idle, before it accepts a request. With a request held high, select falls at the 52nd clock after the drop.
- R10: The address lines hold the accepted address for the whole time select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address |
| req_wdata | input | 4 | Write data |
| ret_req | input | 1 | Retention request (hold memory deselected) |
| rd_data | output | 4 | Last read word |
| done | output | 1 | One-cycle access completion pulse |
| mem_addr | output | 10 | Memory address lines |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_out | output | 4 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 4 | Data sampled from the memory |

## Verification
The bench models the RAM so that it latches data only on the rising edge of the write strobe and drives unknown values whenever it is not being read. A sequencer that samples read data a cycle early, or releases the address or data too soon, therefore returns wrong words. It also measures the setup, pulse, hold and read phase lengths in cycles, so an off-by-one in the ceiling rounding or the timer reload shows up directly. Requests are fired into a running write and into retention; a sequencer that accepts them gives an extra completion or corrupts a word. The recovery exit is timed to the exact cycle, which catches a missing or shortened recovery wait.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_WGAP,
        ST_RETAIN,
        ST_RECOVER
    } ctl_state_t;

    // Round a nanosecond minimum up to whole clock cycles, at least one.
    function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int CW      = 6,
    parameter int RD_CYC  = 50,
    parameter int AS_CYC  = 7,
    parameter int WP_CYC  = 32,
    parameter int WH_CYC  = 13,
    parameter int GAP_CYC = 1,
    parameter int RCV_CYC = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic          ret_req,
    input  logic          tmr_expired,
    output ctl_state_t    state,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          accept,
    output logic          finish_rd,
    output logic          finish_wr
);

    ctl_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ret_req) begin
                    state_nx = ST_RETAIN;
                end else if (req) begin
                    accept   = 1'b1;
                    state_nx = req_we ? ST_WSETUP : ST_READ;
                end
            end
            ST_READ:    if (tmr_expired) state_nx = ST_IDLE;
            ST_WSETUP:  if (tmr_expired) state_nx = ST_WPULSE;
            ST_WPULSE:  if (tmr_expired) state_nx = ST_WHOLD;
            ST_WHOLD:   if (tmr_expired) state_nx = ST_WGAP;
            ST_WGAP:    if (tmr_expired) state_nx = ST_IDLE;
            ST_RETAIN:  if (!ret_req)    state_nx = ST_RECOVER;
            ST_RECOVER: begin
                if (ret_req) begin
                    state_nx = ST_RETAIN;
                end else if (tmr_expired) begin
                    state_nx = ST_IDLE;
                end
            end
        endcase
    end

    // The timer is reloaded on every state change with the length of the
    // state being entered, minus one.
    assign tmr_load = (state_nx != state);

    always_comb begin
        unique case (state_nx)
            ST_READ:    tmr_val = CW'(RD_CYC - 1);
            ST_WSETUP:  tmr_val = CW'(AS_CYC - 1);
            ST_WPULSE:  tmr_val = CW'(WP_CYC - 1);
            ST_WHOLD:   tmr_val = CW'(WH_CYC - 1);
            ST_WGAP:    tmr_val = CW'(GAP_CYC - 1);
            ST_RECOVER: tmr_val = CW'(RCV_CYC - 1);
            ST_IDLE,
            ST_RETAIN:  tmr_val = '0;
        endcase
    end

    assign finish_rd = (state == ST_READ) && tmr_expired;
    assign finish_wr = (state == ST_WGAP) && tmr_expired;

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
    import sram_ctl_pkg::*;
(
    input  ctl_state_t state,
    output logic       cs_n,
    output logic       we_n,
    output logic       dq_oe
);

    always_comb begin
        cs_n  = 1'b1;
        we_n  = 1'b1;
        dq_oe = 1'b0;
        unique case (state)
            ST_READ: begin
                cs_n = 1'b0;
            end
            ST_WSETUP: begin
                cs_n = 1'b0;
            end
            ST_WPULSE: begin
                cs_n  = 1'b0;
                we_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_WHOLD: begin
                cs_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_IDLE, ST_WGAP, ST_RETAIN, ST_RECOVER: begin
                cs_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW        = 10,
    parameter int DW        = 4,
    parameter int CLK_NS    = 4,
    parameter int T_ACC_NS  = 200,
    parameter int T_RCYC_NS = 200,
    parameter int T_WCYC_NS = 200,
    parameter int T_AS_NS   = 25,
    parameter int T_WP_NS   = 125,
    parameter int T_WR_NS   = 50,
    parameter int T_DS_NS   = 75,
    parameter int T_DH_NS   = 30,
    parameter int T_RCV_NS  = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          ret_req,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);

    localparam int RD_CYC  = imax(ns_to_cycles(T_ACC_NS, CLK_NS),
                                  ns_to_cycles(T_RCYC_NS, CLK_NS));
    localparam int AS_CYC  = ns_to_cycles(T_AS_NS, CLK_NS);
    localparam int WP_CYC  = imax(ns_to_cycles(T_WP_NS, CLK_NS),
                                  ns_to_cycles(T_DS_NS, CLK_NS));
    localparam int WH_CYC  = imax(ns_to_cycles(T_WR_NS, CLK_NS),
                                  ns_to_cycles(T_DH_NS, CLK_NS));
    localparam int WC_CYC  = ns_to_cycles(T_WCYC_NS, CLK_NS);
    localparam int GAP_CYC = imax(1, WC_CYC - AS_CYC - WP_CYC - WH_CYC);
    localparam int RCV_CYC = ns_to_cycles(T_RCV_NS, CLK_NS);
    localparam int MAX_CYC = imax(imax(imax(RD_CYC, AS_CYC), imax(WP_CYC, WH_CYC)),
                                  imax(GAP_CYC, RCV_CYC));
    localparam int CW      = $clog2(MAX_CYC + 1);

    ctl_state_t    state;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    logic          accept;
    logic          finish_rd;
    logic          finish_wr;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    sram_ctl_seq #(
        .CW      (CW),
        .RD_CYC  (RD_CYC),
        .AS_CYC  (AS_CYC),
        .WP_CYC  (WP_CYC),
        .WH_CYC  (WH_CYC),
        .GAP_CYC (GAP_CYC),
        .RCV_CYC (RCV_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .req_we      (req_we),
        .ret_req     (ret_req),
        .tmr_expired (tmr_expired),
        .state       (state),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .accept      (accept),
        .finish_rd   (finish_rd),
        .finish_wr   (finish_wr)
    );

    sram_ctl_timer #(
        .W (CW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_ctl_pins u_pins (
        .state (state),
        .cs_n  (mem_cs_n),
        .we_n  (mem_we_n),
        .dq_oe (mem_dq_oe)
    );

    // Request fields are latched at acceptance and held through the access.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= finish_rd || finish_wr;
            if (finish_rd) begin
                rd_data <= mem_dq_in;
            end
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int AW = 10,
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ret_req,
    input logic          done,
    input logic [AW-1:0] mem_addr,
    input logic          mem_cs_n,
    input logic          mem_we_n,
    input logic [DW-1:0] mem_dq_out,
    input logic          mem_dq_oe
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (mem_cs_n && mem_we_n && !mem_dq_oe));

    // R3
    we_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (!mem_cs_n && $stable(mem_addr)));

    // R4
    we_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_cs_n && mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr)));

    // R5
    drive_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_cs_n);

    // R5
    strobe_needs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    // R5
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> !$past(mem_dq_oe));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    retain_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_cs_n) && $past(ret_req)) |-> mem_cs_n);

    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ret_req    (ret_req),
    .done       (done),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_sram_ctl.sv
module sim_sram_ctl;

    // Expected phase lengths at 4 ns, worked out by hand from the requirements.
    localparam int E_RD  = 50;  // R2: 200 ns / 4
    localparam int E_AS  = 7;   // R3: 25 ns -> 6.25 -> 7
    localparam int E_WP  = 32;  // R3: 125 ns -> 31.25 -> 32
    localparam int E_WH  = 13;  // R4: 50 ns -> 12.5 -> 13
    localparam int E_RCV = 50;  // R9: 200 ns / 4

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic       req_we = 1'b0;
    logic [9:0] req_addr = '0;
    logic [3:0] req_wdata = '0;
    logic       ret_req = 1'b0;
    logic [3:0] rd_data;
    logic       done;
    logic [9:0] mem_addr;
    logic       mem_cs_n;
    logic       mem_we_n;
    logic [3:0] mem_dq_out;
    logic       mem_dq_oe;
    logic [3:0] mem_dq_in;

    always #2 clk = ~clk;

    sram_ctl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .ret_req    (ret_req),
        .rd_data    (rd_data),
        .done       (done),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    // Memory model: latches on the strobe's rising edge, drives only when read.
    logic [3:0] sram    [1024];
    logic [3:0] exp_mem [1024];

    initial begin
        for (int i = 0; i < 1024; i++) begin
            sram[i]    = 4'(i ^ (i >> 4));
            exp_mem[i] = 4'(i ^ (i >> 4));
        end
    end

    always @(posedge mem_we_n) begin
        if (rst_n && mem_cs_n === 1'b0) sram[mem_addr] <= mem_dq_out;
    end

    assign mem_dq_in = (mem_cs_n === 1'b0 && mem_we_n === 1'b1) ? sram[mem_addr] : 4'bx;

    typedef struct packed {
        logic       rd;
        logic [9:0] a;
        logic [3:0] d;
    } item_t;

    item_t sbq[$];
    int    checks = 0;
    int    errors = 0;
    int    done_cnt = 0;
    bit    finished = 1'b0;
    bit    in_ret = 1'b0;
    bit    ret_cs_low = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: phase lengths, bus rules and scoreboard comparison.
    int         cs_run = 0;
    int         we_run = 0;
    int         setup_seen = 0;
    bit         saw_we = 1'b0;
    bit         addr_moved = 1'b0;
    bit         bus_bad = 1'b0;
    bit         prev_cs = 1'b1;
    bit         prev_we = 1'b1;
    bit         prev_oe = 1'b0;
    bit         prev_done = 1'b0;
    logic [9:0] prev_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && mem_cs_n) bus_bad = 1'b1;
            if (mem_dq_oe && !mem_cs_n && mem_we_n && !saw_we) bus_bad = 1'b1;
            if (!mem_cs_n && prev_cs && prev_oe) bus_bad = 1'b1;
            if (in_ret && !mem_cs_n) ret_cs_low = 1'b1;
            if (!mem_cs_n) begin
                if (!prev_cs && mem_addr != prev_addr) addr_moved = 1'b1;
                if (!mem_we_n && prev_we) begin
                    setup_seen = cs_run;
                    saw_we = 1'b1;
                end
                cs_run++;
                if (!mem_we_n) we_run++;
            end else if (!prev_cs) begin
                if (saw_we) begin
                    check(setup_seen == E_AS, "R3 setup cycles", setup_seen, E_AS);
                    check(we_run == E_WP, "R3 strobe low cycles", we_run, E_WP);
                    check(cs_run - setup_seen - we_run == E_WH, "R4 hold cycles",
                          cs_run - setup_seen - we_run, E_WH);
                end else begin
                    check(cs_run == E_RD, "R2 read select cycles", cs_run, E_RD);
                end
                check(!addr_moved, "R10 address stable", addr_moved, 0);
                check(!bus_bad, "R5 drive rules", bus_bad, 0);
                cs_run = 0; we_run = 0; saw_we = 1'b0; addr_moved = 1'b0;
            end
            if (done) begin
                done_cnt++;
                if (prev_done) check(1'b0, "R6 done width", 2, 1);
                if (sbq.size() == 0) begin
                    check(1'b0, "R7 unexpected done", 1, 0);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    if (it.rd)
                        check(rd_data === it.d, "R2 read data", int'(rd_data), int'(it.d));
                    else
                        check(sram[it.a] === it.d, "R4 written word", int'(sram[it.a]), int'(it.d));
                end
            end
            prev_cs   = mem_cs_n;
            prev_we   = mem_we_n;
            prev_oe   = mem_dq_oe;
            prev_done = done;
            prev_addr = mem_addr;
        end
    end

    task automatic pulse_req(input bit we, input logic [9:0] a, input logic [3:0] d);
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic push(input bit we, input logic [9:0] a, input logic [3:0] d);
        item_t it;
        it.rd = !we;
        it.a  = a;
        if (we) begin
            exp_mem[a] = d;
            it.d = d;
        end else begin
            it.d = exp_mem[a];
        end
        sbq.push_back(it);
    endtask

    task automatic wait_done(input int start);
        while (done_cnt == start) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic access(input bit we, input logic [9:0] a, input logic [3:0] d);
        int s;
        s = done_cnt;
        push(we, a, d);
        pulse_req(we, a, d);
        wait_done(s);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(mem_cs_n === 1'b1, "R1 select high", mem_cs_n, 1);
        check(mem_we_n === 1'b1, "R1 strobe high", mem_we_n, 1);
        check(mem_dq_oe === 1'b0, "R1 drive off", mem_dq_oe, 0);
        check(done === 1'b0, "R1 done low", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs_n === 1'b1 && done === 1'b0, "R1 after release", mem_cs_n, 1);

        // R2 R3 R4 R6: writes at edge addresses, then read back
        access(1'b1, 10'd0, 4'hA);
        access(1'b1, 10'd1023, 4'h5);
        access(1'b1, 10'h155, 4'hF);
        access(1'b1, 10'h2AA, 4'h0);
        access(1'b0, 10'd0, 4'h0);     // read straight after a write (R5 turnaround)
        access(1'b0, 10'd1023, 4'h0);
        access(1'b0, 10'h155, 4'h0);
        access(1'b0, 10'h2AA, 4'h0);
        access(1'b0, 10'h0F3, 4'h0);   // untouched word
        access(1'b1, 10'h155, 4'h3);   // overwrite
        access(1'b0, 10'h155, 4'h0);

        // R7: requests during a running write are ignored
        begin
            int s;
            s = done_cnt;
            push(1'b1, 10'h040, 4'h6);
            pulse_req(1'b1, 10'h040, 4'h6);
            repeat (10) @(negedge clk);
            pulse_req(1'b0, 10'h041, 4'h0);
            repeat (20) @(negedge clk);
            pulse_req(1'b1, 10'h041, 4'h9);
            wait_done(s);
            repeat (5) @(negedge clk);
            check(done_cnt == s + 1, "R7 single completion", done_cnt - s, 1);
        end
        access(1'b0, 10'h041, 4'h0);   // R7: must still hold its old value
        access(1'b0, 10'h040, 4'h0);

        // R8: retention wins over a same-cycle request; requests ignored inside
        begin
            int s;
            int k;
            s = done_cnt;
            @(negedge clk);
            ret_req = 1'b1; in_ret = 1'b1;
            req = 1'b1; req_we = 1'b1; req_addr = 10'h077; req_wdata = 4'hE;
            @(negedge clk);
            req = 1'b0;
            repeat (10) @(negedge clk);
            pulse_req(1'b1, 10'h077, 4'hE);
            repeat (10) @(negedge clk);
            check(!ret_cs_low, "R8 select held high", ret_cs_low, 0);
            check(done_cnt == s, "R8 no completion", done_cnt - s, 0);
            // R9: drop retention with a request held high
            ret_req = 1'b0; in_ret = 1'b0;
            req = 1'b1; req_we = 1'b0; req_addr = 10'h077;
            push(1'b0, 10'h077, 4'h0);
            k = 0;
            do begin
                @(negedge clk);
                k++;
            end while (mem_cs_n !== 1'b0 && k < 200);
            req = 1'b0;
            check(k == E_RCV + 2, "R9 recovery delay", k, E_RCV + 2);
            wait_done(s);
        end
        access(1'b0, 10'd1023, 4'h0);

        repeat (5) @(negedge clk);
        check(sbq.size() == 0, "R6 every access completed", sbq.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule